// File: doc/BRIEF.md
# Four-Channel Prioritized Block Transfer Engine

This block moves data between two addresses on a shared memory bus without processor help. It holds four independent channels. Software programs each channel with a start source, a start destination, a unit count and a control word. The control word sets the unit width (16 or 32 bits), how each address moves after a unit, the start condition, repeat and interrupt enable. A channel can start as soon as it is enabled, on a horizontal-blank strobe, on a vertical-blank strobe, or on a per-channel special request strobe.

A single engine serves the channels. Between units it picks the pending channel with the lowest number. Each unit is one read followed by one write on a valid/ready master port. After the write it steps the channel's working addresses and decrements its count. When the count runs out, the channel either disarms and clears its enable, or, if repeat is set and the start condition is a strobe, reloads its count and waits for the next strobe. It also raises a one-cycle interrupt pulse if interrupts are enabled.

The engine state machine has three states. `ST_IDLE` waits for a pending channel. The transition *grant* latches the winner and goes to `ST_READ`. `ST_READ` holds the read request. The transition *read_done* happens on read handshake, stores the data and goes to `ST_WRITE`. `ST_WRITE` holds the write request. The transition *write_done* happens on write handshake, advances the channel and returns to `ST_IDLE`, where arbitration is redone.

Top module: `dma4_engine`

## Requirements
- R1: After reset no bus request is raised, no interrupt line is high, and every channel's control readback is 0.
- R2: Register select 0 (source) and 1 (destination) store the written address with bit 0 forced to 0, so a 16-bit unit never uses an odd address.
- R3: Control bits 8:7 give the source step and bits 6:5 the destination step. Code 0 adds the unit size after each unit, code 1 subtracts it, code 2 leaves the address unchanged, and code 3 adds it. Bit 10 selects 32-bit units (step 4) over 16-bit units (step 2). The written data of each unit equals the data read in that unit.
- R4: Register select 2 holds the unit count. A value of 0 means SHORT_MAX units (default 0x4000) on channels 0 to N_CH-2, and LONG_MAX units (default 0x10000) on the last channel.
- R5: Register select 3 writes the control word, and bit 15 is enable. Only a write that changes enable from 0 to 1 copies source, destination and count into the working copies and arms the start condition. A control write that leaves enable at 1 changes no working address.
- R6: Control bits 13:12 select the start condition: 0 starts at once, 1 on a vertical-blank strobe, 2 on a horizontal-blank strobe, 3 on the channel's special strobe. A strobe for another condition does not start the channel. Condition 3 on channel 0 never starts it.
- R7: When several channels are pending, the lowest-numbered one is served. An armed channel runs its whole count before any higher-numbered channel gets a unit.
- R8: In 32-bit mode, the first unit after arming uses both addresses with bits 1:0 cleared, and later units step from those aligned addresses.
- R9: When the count runs out without repeat, or with start condition 0, enable clears. The readback then equals the written control word with bits 15 and 4:0 cleared.
- R10: With repeat (bit 9) and a strobe start condition, completion reloads the count and keeps enable set. Destination code 3 also reloads the destination, while the source continues from where it stopped.
- R11: A channel with bit 14 set raises its interrupt line for exactly one cycle when its count runs out. It raises no pulse otherwise.
- R12: Each unit is a read followed by a write. A raised request keeps its address, direction and data until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | ADDR_W | Write data |
| rd_ch | input | CH_W | Channel whose control word is read back |
| rd_ctrl | output | 16 | Control readback |
| hblank_stb | input | 1 | Horizontal-blank strobe |
| vblank_stb | input | 1 | Vertical-blank strobe |
| special_stb | input | N_CH | Per-channel special request strobes |
| m_valid | output | 1 | Bus request |
| m_write | output | 1 | 1 = write, 0 = read |
| m_size32 | output | 1 | 1 = 32-bit unit |
| m_addr | output | ADDR_W | Bus address |
| m_wdata | output | 32 | Write data |
| m_ready | input | 1 | Bus accepts the request |
| m_rdata | input | 32 | Read data, valid with ready on a read |
| irq | output | N_CH | Per-channel completion pulses |

## Verification
The hardest situation to reach is a repeat channel completing a burst. It must keep enable set, restart its destination, and carry on from its old source position on the next strobe. The bench reaches it by arming a horizontal-blank channel with repeat and destination code 3, then giving two strobes with the bus quiet between them. It then compares both bursts' address logs against arithmetic expectations. The sweep over all sixteen step-code pairs at both widths uses an odd-halfword base, so 32-bit alignment shows on every first unit.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } eng_state_t;

    // register selects
    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    // address step codes
    localparam logic [1:0] STEP_UP     = 2'd0;
    localparam logic [1:0] STEP_DOWN   = 2'd1;
    localparam logic [1:0] STEP_HOLD   = 2'd2;
    localparam logic [1:0] STEP_RELOAD = 2'd3;

    // start conditions
    localparam logic [1:0] START_NOW  = 2'd0;
    localparam logic [1:0] START_VBL  = 2'd1;
    localparam logic [1:0] START_HBL  = 2'd2;
    localparam logic [1:0] START_SPEC = 2'd3;

    // control word bit positions
    localparam int B_DSTEP = 5;
    localparam int B_SSTEP = 7;
    localparam int B_RPT   = 9;
    localparam int B_WIDE  = 10;
    localparam int B_AUX   = 11;
    localparam int B_START = 12;
    localparam int B_IE    = 14;
    localparam int B_EN    = 15;

endpackage

// File: rtl/dma4_pick.sv
module dma4_pick #(
    parameter int N_CH = 4,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] req,
    output logic            any,
    output logic [CH_W-1:0] idx
);
    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        idx = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = CH_W'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W = 16,
    parameter logic [CNT_W:0] MAX_CNT = 17'h04000,
    parameter bit ALLOW_SPECIAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              special,
    input  logic              adv,
    output logic              pending,
    output logic [ADDR_W-1:0] bus_src,
    output logic [ADDR_W-1:0] bus_dst,
    output logic              wide,
    output logic [15:0]       ctrl_rd,
    output logic              irq
);
    localparam int WC_W = CNT_W + 1;

    logic [ADDR_W-1:0] src_q, dst_q, wsrc_q, wdst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WC_W-1:0]   wcnt_q;
    logic              en_q, ie_q, rpt_q, wide_q, aux_q, pend_q, first_q;
    logic [1:0]        sstep_q, dstep_q, start_q;

    logic [WC_W-1:0]   eff_cnt;
    logic [ADDR_W-1:0] unit_sz, src_next, dst_next;
    logic              new_en, last_unit, trig;

    assign eff_cnt = (cnt_q == '0) ? MAX_CNT : {1'b0, cnt_q};
    assign unit_sz = wide_q ? ADDR_W'(4) : ADDR_W'(2);
    assign new_en  = wr_data[B_EN];
    assign last_unit = (wcnt_q == WC_W'(1));

    // aligned view on the first 32-bit unit after arming
    assign bus_src = (first_q && wide_q) ? {wsrc_q[ADDR_W-1:2], 2'b00} : wsrc_q;
    assign bus_dst = (first_q && wide_q) ? {wdst_q[ADDR_W-1:2], 2'b00} : wdst_q;

    always_comb begin
        unique case (sstep_q)
            STEP_DOWN: src_next = bus_src - unit_sz;
            STEP_HOLD: src_next = bus_src;
            default:   src_next = bus_src + unit_sz;
        endcase
        unique case (dstep_q)
            STEP_DOWN: dst_next = bus_dst - unit_sz;
            STEP_HOLD: dst_next = bus_dst;
            default:   dst_next = bus_dst + unit_sz;
        endcase
    end

    always_comb begin
        trig = 1'b0;
        unique case (start_q)
            START_VBL:  trig = vblank;
            START_HBL:  trig = hblank;
            START_SPEC: trig = ALLOW_SPECIAL && special;
            default:    trig = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            wsrc_q  <= '0;
            wdst_q  <= '0;
            cnt_q   <= '0;
            wcnt_q  <= '0;
            en_q    <= 1'b0;
            ie_q    <= 1'b0;
            rpt_q   <= 1'b0;
            wide_q  <= 1'b0;
            aux_q   <= 1'b0;
            pend_q  <= 1'b0;
            first_q <= 1'b0;
            sstep_q <= '0;
            dstep_q <= '0;
            start_q <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;

            if (en_q && !pend_q && trig) pend_q <= 1'b1;

            if (adv && en_q && pend_q) begin
                wsrc_q  <= src_next;
                wdst_q  <= dst_next;
                first_q <= 1'b0;
                wcnt_q  <= wcnt_q - WC_W'(1);
                if (last_unit) begin
                    pend_q <= 1'b0;
                    irq    <= ie_q;
                    if (rpt_q && start_q != START_NOW) begin
                        wcnt_q  <= eff_cnt;
                        first_q <= 1'b1;
                        if (dstep_q == STEP_RELOAD) wdst_q <= dst_q;
                    end else begin
                        en_q <= 1'b0;
                    end
                end
            end

            if (wr_en) begin
                unique case (wr_sel)
                    SEL_SRC: src_q <= {wr_data[ADDR_W-1:1], 1'b0};
                    SEL_DST: dst_q <= {wr_data[ADDR_W-1:1], 1'b0};
                    SEL_CNT: cnt_q <= wr_data[CNT_W-1:0];
                    SEL_CTRL: begin
                        en_q    <= new_en;
                        ie_q    <= wr_data[B_IE];
                        start_q <= wr_data[B_START +: 2];
                        aux_q   <= wr_data[B_AUX];
                        wide_q  <= wr_data[B_WIDE];
                        rpt_q   <= wr_data[B_RPT];
                        sstep_q <= wr_data[B_SSTEP +: 2];
                        dstep_q <= wr_data[B_DSTEP +: 2];
                        if (!en_q && new_en) begin
                            wsrc_q  <= src_q;
                            wdst_q  <= dst_q;
                            wcnt_q  <= eff_cnt;
                            first_q <= 1'b1;
                            pend_q  <= (wr_data[B_START +: 2] == START_NOW);
                        end else if (!new_en) begin
                            pend_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pending = pend_q;
    assign wide    = wide_q;
    assign ctrl_rd = {en_q, ie_q, start_q, aux_q, wide_q, rpt_q, sstep_q, dstep_q, 5'b00000};

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int ADDR_W = 32,
    parameter int CNT_W = 16,
    parameter logic [CNT_W:0] SHORT_MAX = 17'h04000,
    parameter logic [CNT_W:0] LONG_MAX  = 17'h10000,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [15:0]       rd_ctrl,
    input  logic              hblank_stb,
    input  logic              vblank_stb,
    input  logic [N_CH-1:0]   special_stb,
    output logic              m_valid,
    output logic              m_write,
    output logic              m_size32,
    output logic [ADDR_W-1:0] m_addr,
    output logic [31:0]       m_wdata,
    input  logic              m_ready,
    input  logic [31:0]       m_rdata,
    output logic [N_CH-1:0]   irq
);
    logic [N_CH-1:0]   ch_pend, ch_wide, ch_adv;
    logic [ADDR_W-1:0] ch_src [N_CH];
    logic [ADDR_W-1:0] ch_dst [N_CH];
    logic [15:0]       ch_ctrl [N_CH];

    eng_state_t        state_q, state_d;
    logic [CH_W-1:0]   cur_q, pick_idx;
    logic [31:0]       data_q;
    logic              pick_any;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        localparam logic [CNT_W:0] CH_MAX = (g == N_CH - 1) ? LONG_MAX : SHORT_MAX;
        dma4_chan #(
            .ADDR_W(ADDR_W),
            .CNT_W(CNT_W),
            .MAX_CNT(CH_MAX),
            .ALLOW_SPECIAL(g != 0)
        ) u_chan (
            .clk(clk),
            .rst_n(rst_n),
            .wr_en(cfg_we && (cfg_ch == CH_W'(g))),
            .wr_sel(cfg_sel),
            .wr_data(cfg_wdata),
            .hblank(hblank_stb),
            .vblank(vblank_stb),
            .special(special_stb[g]),
            .adv(ch_adv[g]),
            .pending(ch_pend[g]),
            .bus_src(ch_src[g]),
            .bus_dst(ch_dst[g]),
            .wide(ch_wide[g]),
            .ctrl_rd(ch_ctrl[g]),
            .irq(irq[g])
        );
    end

    dma4_pick #(.N_CH(N_CH)) u_pick (
        .req(ch_pend),
        .any(pick_any),
        .idx(pick_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pick_any) cur_q <= pick_idx;
            if (state_q == ST_READ && m_ready)  data_q <= m_rdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pick_any) state_d = ST_READ;
            ST_READ:  if (m_ready)  state_d = ST_WRITE;
            ST_WRITE: if (m_ready)  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        m_valid  = 1'b0;
        m_write  = 1'b0;
        m_addr   = ch_src[cur_q];
        m_size32 = ch_wide[cur_q];
        m_wdata  = data_q;
        ch_adv   = '0;
        unique case (state_q)
            ST_READ: begin
                m_valid = 1'b1;
            end
            ST_WRITE: begin
                m_valid = 1'b1;
                m_write = 1'b1;
                m_addr  = ch_dst[cur_q];
                if (m_ready) ch_adv[cur_q] = 1'b1;
            end
            default: ;
        endcase
    end

    assign rd_ctrl = ch_ctrl[rd_ch];

endmodule

// File: rtl/dma4_checker.sv
module dma4_checker #(
    parameter int N_CH = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_valid,
    input logic              m_write,
    input logic              m_size32,
    input logic [ADDR_W-1:0] m_addr,
    input logic [31:0]       m_wdata,
    input logic              m_ready,
    input logic [N_CH-1:0]   irq
);
    // R12: an unanswered request holds still
    a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)));

    // R12: an accepted read is followed by its write
    a_r12_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && !m_write) |=> (m_valid && m_write));

    // R2: no odd bus address
    a_r2_even_address: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_addr[0] == 1'b0));

    // R8: 32-bit units stay word aligned
    a_r8_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_size32) |-> (m_addr[1:0] == 2'b00));

    // R11: completion pulses last one cycle
    a_r11_single_cycle_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |=> ((irq & $past(irq)) == '0));

    // R11: one engine completes at most one channel per cycle
    a_r11_one_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));

endmodule

bind dma4_engine dma4_checker #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dma4_checker (
    .clk(clk),
    .rst_n(rst_n),
    .m_valid(m_valid),
    .m_write(m_write),
    .m_size32(m_size32),
    .m_addr(m_addr),
    .m_wdata(m_wdata),
    .m_ready(m_ready),
    .irq(irq)
);

// File: tb/dma4_engine_tb.sv
module dma4_engine_tb_top;
    localparam int N_CH = 4;
    localparam int CH_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [CH_W-1:0] cfg_ch = '0;
    logic [1:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [CH_W-1:0] rd_ch = '0;
    logic [15:0] rd_ctrl;
    logic hblank_stb = 1'b0;
    logic vblank_stb = 1'b0;
    logic [N_CH-1:0] special_stb = '0;
    logic m_valid, m_write, m_size32;
    logic [31:0] m_addr, m_wdata;
    logic m_ready = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [N_CH-1:0] irq;

    always #10 clk = ~clk;

    dma4_engine #(
        .N_CH(N_CH), .ADDR_W(32), .CNT_W(16),
        .SHORT_MAX(17'h00020), .LONG_MAX(17'h00040)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_ch(rd_ch), .rd_ctrl(rd_ctrl),
        .hblank_stb(hblank_stb), .vblank_stb(vblank_stb), .special_stb(special_stb),
        .m_valid(m_valid), .m_write(m_write), .m_size32(m_size32), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int nlog = 0;
    logic [31:0] lg_addr [256];
    logic [31:0] lg_data [256];
    logic        lg_wr   [256];
    int irq_cnt [N_CH];

    function automatic logic [31:0] rd_fn(input logic [31:0] a);
        return {a[15:0] ^ 16'hC35A, ~a[15:0]};
    endfunction

    // bus responder and monitor, one cycle of latency per request
    initial begin
        for (int i = 0; i < N_CH; i++) irq_cnt[i] = 0;
        forever begin
            @(negedge clk);
            for (int i = 0; i < N_CH; i++) if (irq[i]) irq_cnt[i]++;
            if (m_ready) begin
                m_ready = 1'b0;
            end else if (m_valid) begin
                m_ready = 1'b1;
                m_rdata = m_write ? 32'h0 : rd_fn(m_addr);
                if (nlog < 256) begin
                    lg_addr[nlog] = m_addr;
                    lg_wr[nlog]   = m_write;
                    lg_data[nlog] = m_write ? m_wdata : rd_fn(m_addr);
                end
                nlog++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_quiet();
        int quiet = 0;
        while (quiet < 10) begin
            @(negedge clk);
            if (m_valid) quiet = 0; else quiet++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] ctrl_word(input bit en, input bit ie, input logic [1:0] st,
                                              input bit wide, input bit rpt,
                                              input logic [1:0] sm, input logic [1:0] dm);
        return {en, ie, st, 1'b0, wide, rpt, sm, dm, 5'b0};
    endfunction

    function automatic int dir_of(input logic [1:0] m);
        return (m == 2'd1) ? -1 : (m == 2'd2) ? 0 : 1;
    endfunction

    task automatic read_ctrl(input int ch, output logic [15:0] v);
        @(negedge clk);
        rd_ch = CH_W'(ch);
        #1 v = rd_ctrl;
    endtask

    initial begin
        logic [15:0] rv;
        logic [15:0] cw;
        bit ok;
        repeat (5) @(negedge clk);
        // R1: reset state
        ok = !m_valid && (irq == '0);
        for (int c = 0; c < N_CH; c++) begin
            read_ctrl(c, rv);
            if (rv != 16'h0) ok = 0;
        end
        check(ok, "R1 reset outputs", {m_valid, 3'b0, irq}, 32'h0);
        rst_n = 1'b1;
        idle(3);

        // R3 R8 R9 R12: sweep step codes and width on channel 1
        for (int w = 0; w < 2; w++) begin
            for (int sm = 0; sm < 4; sm++) begin
                for (int dm = 0; dm < 4; dm++) begin
                    logic [31:0] sb, db, sa, da, st;
                    nlog = 0;
                    cfg(1, 2'd0, 32'h1000_0102);
                    cfg(1, 2'd1, 32'h2000_0206);
                    cfg(1, 2'd2, 32'd3);
                    cw = ctrl_word(1, 0, 2'd0, w[0], 0, sm[1:0], dm[1:0]) | 16'h001F;
                    cfg(1, 2'd3, {16'h0, cw});
                    wait_quiet();
                    st = (w == 1) ? 32'd4 : 32'd2;
                    sb = (w == 1) ? 32'h1000_0100 : 32'h1000_0102;
                    db = (w == 1) ? 32'h2000_0204 : 32'h2000_0206;
                    ok = (nlog == 6);
                    if (ok) for (int k = 0; k < 3; k++) begin
                        sa = sb + 32'(dir_of(sm[1:0]) * k * int'(st));
                        da = db + 32'(dir_of(dm[1:0]) * k * int'(st));
                        if (lg_wr[2*k] || lg_addr[2*k] != sa) ok = 0;
                        if (!lg_wr[2*k+1] || lg_addr[2*k+1] != da || lg_data[2*k+1] != rd_fn(sa)) ok = 0;
                    end
                    check(ok, $sformatf("R3 R8 R12 sweep w=%0d s=%0d d=%0d", w, sm, dm),
                          32'(nlog), 32'd6);
                    read_ctrl(1, rv);
                    check(rv == (cw & 16'h7FE0), "R9 readback after completion", {16'h0, rv},
                          {16'h0, cw & 16'h7FE0});
                end
            end
        end
        check(irq_cnt[1] == 0, "R11 no pulse without enable bit", irq_cnt[1], 0);

        // R2: odd addresses lose bit 0
        nlog = 0;
        cfg(2, 2'd0, 32'h3000_0011);
        cfg(2, 2'd1, 32'h4000_0023);
        cfg(2, 2'd2, 32'd1);
        cfg(2, 2'd3, {16'h0, ctrl_word(1, 1, 2'd0, 0, 0, 2'd2, 2'd2)});
        wait_quiet();
        check(nlog == 2 && lg_addr[0] == 32'h3000_0010, "R2 source bit0", lg_addr[0], 32'h3000_0010);
        check(nlog == 2 && lg_addr[1] == 32'h4000_0022, "R2 destination bit0", lg_addr[1], 32'h4000_0022);
        // R11: enabled pulse
        check(irq_cnt[2] == 1, "R11 single completion pulse", irq_cnt[2], 1);

        // R4: zero count maximum
        nlog = 0;
        cfg(0, 2'd0, 32'h100); cfg(0, 2'd1, 32'h200); cfg(0, 2'd2, 32'd0);
        cfg(0, 2'd3, {16'h0, ctrl_word(1, 0, 2'd0, 0, 0, 2'd0, 2'd0)});
        wait_quiet();
        check(nlog == 2 * 32'h20, "R4 zero count short channel", nlog, 2 * 32'h20);
        nlog = 0;
        cfg(3, 2'd0, 32'h100); cfg(3, 2'd1, 32'h200); cfg(3, 2'd2, 32'd0);
        cfg(3, 2'd3, {16'h0, ctrl_word(1, 0, 2'd0, 0, 0, 2'd0, 2'd0)});
        wait_quiet();
        check(nlog == 2 * 32'h40, "R4 zero count last channel", nlog, 2 * 32'h40);

        // R5 R6: vblank channel, rewrite while enabled
        nlog = 0;
        cfg(1, 2'd0, 32'h0A00); cfg(1, 2'd1, 32'h0B00); cfg(1, 2'd2, 32'd2);
        cw = ctrl_word(1, 0, 2'd1, 0, 0, 2'd0, 2'd0);
        cfg(1, 2'd3, {16'h0, cw});
        cfg(1, 2'd0, 32'h0C00);
        cfg(1, 2'd3, {16'h0, cw});
        idle(20);
        check(nlog == 0, "R6 vblank channel waits", nlog, 0);
        @(negedge clk); hblank_stb = 1'b1; @(negedge clk); hblank_stb = 1'b0;
        idle(20);
        check(nlog == 0, "R6 wrong strobe ignored", nlog, 0);
        @(negedge clk); vblank_stb = 1'b1; @(negedge clk); vblank_stb = 1'b0;
        wait_quiet();
        check(nlog == 4 && lg_addr[0] == 32'h0A00 && lg_addr[2] == 32'h0A02,
              "R5 enabled rewrite keeps working source", lg_addr[0], 32'h0A00);

        // R6: special on channel 0 ignored, on channel 2 honoured
        nlog = 0;
        cfg(0, 2'd2, 32'd1);
        cfg(0, 2'd3, {16'h0, ctrl_word(1, 0, 2'd3, 0, 0, 2'd0, 2'd0)});
        @(negedge clk); special_stb = 4'b0001; @(negedge clk); special_stb = 4'b0000;
        idle(20);
        check(nlog == 0, "R6 special ignored on channel 0", nlog, 0);
        cfg(0, 2'd3, 32'h0);
        cfg(2, 2'd0, 32'h0D00); cfg(2, 2'd2, 32'd1);
        cfg(2, 2'd3, {16'h0, ctrl_word(1, 0, 2'd3, 0, 0, 2'd0, 2'd0)});
        @(negedge clk); special_stb = 4'b0100; @(negedge clk); special_stb = 4'b0000;
        wait_quiet();
        check(nlog == 2 && lg_addr[0] == 32'h0D00, "R6 special starts channel 2", lg_addr[0], 32'h0D00);

        // R7: priority between channels 2 and 1 on the same strobe
        nlog = 0;
        cfg(2, 2'd0, 32'h7000); cfg(2, 2'd1, 32'h7800); cfg(2, 2'd2, 32'd3);
        cfg(2, 2'd3, {16'h0, ctrl_word(1, 0, 2'd1, 0, 0, 2'd0, 2'd0)});
        cfg(1, 2'd0, 32'h6000); cfg(1, 2'd1, 32'h6800); cfg(1, 2'd2, 32'd3);
        cfg(1, 2'd3, {16'h0, ctrl_word(1, 0, 2'd1, 0, 0, 2'd0, 2'd0)});
        @(negedge clk); vblank_stb = 1'b1; @(negedge clk); vblank_stb = 1'b0;
        wait_quiet();
        ok = (nlog == 12);
        if (ok) for (int k = 0; k < 3; k++) begin
            if (lg_addr[2*k] != 32'h6000 + 32'(2*k)) ok = 0;
            if (lg_addr[6+2*k] != 32'h7000 + 32'(2*k)) ok = 0;
        end
        check(ok, "R7 lowest channel runs first", lg_addr[0], 32'h6000);

        // R10: repeat with destination reload on hblank
        nlog = 0;
        cfg(3, 2'd0, 32'h0500); cfg(3, 2'd1, 32'h0600); cfg(3, 2'd2, 32'd2);
        cfg(3, 2'd3, {16'h0, ctrl_word(1, 0, 2'd2, 0, 1, 2'd0, 2'd3)});
        @(negedge clk); hblank_stb = 1'b1; @(negedge clk); hblank_stb = 1'b0;
        wait_quiet();
        read_ctrl(3, rv);
        check(rv[15] == 1'b1, "R10 enable kept after burst", rv[15], 1);
        @(negedge clk); hblank_stb = 1'b1; @(negedge clk); hblank_stb = 1'b0;
        wait_quiet();
        ok = (nlog == 8) && lg_addr[1] == 32'h0600 && lg_addr[3] == 32'h0602
             && lg_addr[4] == 32'h0504 && lg_addr[6] == 32'h0506
             && lg_addr[5] == 32'h0600 && lg_addr[7] == 32'h0602;
        check(ok, "R10 destination reload, source continues", lg_addr[4], 32'h0504);
        cfg(3, 2'd3, 32'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule